// File: doc/BRIEF.md
# Serial-Loaded Latched Switch Control Register

This block is the low-voltage control logic for a bank of eight independent on/off switches. A bit stream arrives on one serial data input and is shifted into an 8-stage register on each rising edge of a serial clock. The new bit enters stage 0 and every earlier bit moves one stage toward stage 7. A latch stage sits between the register and the eight switch-enable outputs. Its load control is active low. While the control is low the outputs follow the register. On the control's rising edge the current register value is frozen, and it stays frozen while the control is high.

A clear input, when high, forces every switch off at once, whatever the clock and load control are doing. The clear acts on the latch stage only, so the shifted data is kept. Stage 7 drives a serial output, which lets a second block take its serial input from the first. Such a chain is loaded from one stream and updated by one shared load control. Level shifters and the switches themselves lie outside the block.

Top module: `swctl_shift_latch`

## Requirements
- R1: On each rising edge of `sclk_i` the register takes `sdi_i` into stage 0 and moves every stage n to stage n+1. After eight clocks the first bit shifted in sits in stage 7.
- R2: `sdo_o` equals register stage 7. It is 1 exactly when that stage holds a 1.
- R3: While `load_ni` is 0 and `clr_i` is 0, `sw_en_o` equals the register contents and follows every shift.
- R4: On the rising edge of `load_ni` the register value is captured. While `load_ni` stays 1, shifting does not change `sw_en_o`.
- R5: While `clr_i` is 1, `sw_en_o` is all zero, whatever `load_ni`, `sclk_i` and `sdi_i` do.
- R6: `clr_i` does not alter the shift register. Shifting continues during a clear, and releasing the clear with `load_ni` at 0 shows the register contents again.
- R7: Bit n of `sw_en_o` drives switch n for n = 0..7, with 1 = on and 0 = off. Each bit depends only on its own register stage.
- R8: While `rst_ni` is 0, the register and the held state are all zero, `sw_en_o` is 0 and `sdo_o` is 0.
- R9: When two blocks are chained (`sdo_o` of the first feeds `sdi_i` of the second), shifting a 16-bit stream MSB first leaves the upper byte in the second block and the lower byte in the first.
- R10: A clear while `load_ni` is 1 empties the held state. After the clear is released, the outputs stay off until `load_ni` next goes low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk_i | input | 1 | Serial shift clock; the register shifts on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sdi_i | input | 1 | Serial data into stage 0 |
| load_ni | input | 1 | Latch control, active low: 0 = outputs follow the register, rising edge = capture |
| clr_i | input | 1 | Asynchronous clear of the latch stage, active high |
| sw_en_o | output | 8 | Switch enables, bit n drives switch n, 1 = on |
| sdo_o | output | 1 | Serial data out from stage 7, used for chaining |

## Verification
The bench shifts bytes while `load_ni` is high and confirms that the outputs keep their old value. A latch that passed data through while closed would show the new byte early. It raises the clear both with the latch open and with it closed, and shifts during the clear. A clear that also wiped the register would show zero after release instead of the byte shifted during the clear. A clear that only masked the outputs would bring back a stale captured value while `load_ni` is still high. A walking-one load and a 16-bit two-block chain expose a reversed shift direction, a stage-7 tap taken from the wrong end, and a one-bit slip across the block boundary.

// File: rtl/swctl_pkg.sv
package swctl_pkg;

  // Default number of switch channels.
  localparam int unsigned SWCTL_DEF_CH = 8;

  // How the output gate chooses each switch enable.
  typedef enum logic [1:0] {
    LM_FOLLOW    = 2'd0,  // outputs track the live shift register
    LM_HOLD      = 2'd1,  // outputs show the captured copy
    LM_FORCE_OFF = 2'd2   // clear active: all switches off
  } latch_mode_e;

  // Clear wins over everything. A high load control selects the held copy.
  function automatic latch_mode_e pick_mode(input logic clr, input logic load_n);
    if (clr)         return LM_FORCE_OFF;
    else if (load_n) return LM_HOLD;
    else             return LM_FOLLOW;
  endfunction

  // Per-channel output selection.
  function automatic logic pick_bit(input latch_mode_e m, input logic held,
                                    input logic live);
    case (m)
      LM_FORCE_OFF: return 1'b0;
      LM_HOLD:      return held;
      default:      return live;
    endcase
  endfunction

endpackage

// File: rtl/swctl_shift_stage.sv
module swctl_shift_stage #(
  parameter int unsigned NUM_SW = 8
) (
  input  logic              sclk_i,
  input  logic              rst_ni,
  input  logic              sdi_i,
  output logic [NUM_SW-1:0] shreg_o,
  output logic              sdo_o
);
  localparam int unsigned TOP = NUM_SW - 1;

  // New bit into stage 0; stage n moves to n+1.
  function automatic logic [NUM_SW-1:0] step(input logic [NUM_SW-1:0] cur,
                                             input logic bin);
    return {cur[TOP-1:0], bin};
  endfunction

  logic [NUM_SW-1:0] shreg_q;

  always_ff @(posedge sclk_i or negedge rst_ni) begin
    if (!rst_ni) shreg_q <= '0;
    else         shreg_q <= step(shreg_q, sdi_i);
  end

  assign shreg_o = shreg_q;
  assign sdo_o   = shreg_q[TOP];
endmodule

// File: rtl/swctl_hold_stage.sv
module swctl_hold_stage #(
  parameter int unsigned NUM_SW = 8
) (
  input  logic              load_ni,
  input  logic              clr_i,
  input  logic              rst_ni,
  input  logic [NUM_SW-1:0] live_i,
  output logic [NUM_SW-1:0] held_o,
  output logic              cap_tog_o
);
  logic [NUM_SW-1:0] held_q;
  logic              cap_tog_q;

  // Capture on the rising load edge. Clear and reset empty the copy at once.
  always_ff @(posedge load_ni or posedge clr_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q    <= '0;
      cap_tog_q <= 1'b0;
    end else if (clr_i) begin
      held_q    <= '0;
      cap_tog_q <= ~cap_tog_q;
    end else begin
      held_q    <= live_i;
      cap_tog_q <= ~cap_tog_q;
    end
  end

  assign held_o    = held_q;
  assign cap_tog_o = cap_tog_q;
endmodule

// File: rtl/swctl_out_gate.sv
module swctl_out_gate
  import swctl_pkg::*;
#(
  parameter int unsigned NUM_SW = 8
) (
  input  latch_mode_e       mode_i,
  input  logic [NUM_SW-1:0] held_i,
  input  logic [NUM_SW-1:0] live_i,
  output logic [NUM_SW-1:0] sw_en_o
);
  for (genvar g = 0; g < NUM_SW; g++) begin : g_ch
    assign sw_en_o[g] = pick_bit(mode_i, held_i[g], live_i[g]);
  end
endmodule

// File: rtl/swctl_shift_latch.sv
module swctl_shift_latch
  import swctl_pkg::*;
#(
  parameter int unsigned NUM_SW = SWCTL_DEF_CH
) (
  input  logic              sclk_i,
  input  logic              rst_ni,
  input  logic              sdi_i,
  input  logic              load_ni,
  input  logic              clr_i,
  output logic [NUM_SW-1:0] sw_en_o,
  output logic              sdo_o
);
  // Named internal wires, also observed by the bound checker.
  logic [NUM_SW-1:0] shreg_w;
  logic [NUM_SW-1:0] held_w;
  logic              cap_tog_w;
  latch_mode_e       mode_w;

  assign mode_w = pick_mode(clr_i, load_ni);

  swctl_shift_stage #(.NUM_SW(NUM_SW)) u_shift (
    .sclk_i (sclk_i),
    .rst_ni (rst_ni),
    .sdi_i  (sdi_i),
    .shreg_o(shreg_w),
    .sdo_o  (sdo_o)
  );

  swctl_hold_stage #(.NUM_SW(NUM_SW)) u_hold (
    .load_ni  (load_ni),
    .clr_i    (clr_i),
    .rst_ni   (rst_ni),
    .live_i   (shreg_w),
    .held_o   (held_w),
    .cap_tog_o(cap_tog_w)
  );

  swctl_out_gate #(.NUM_SW(NUM_SW)) u_gate (
    .mode_i (mode_w),
    .held_i (held_w),
    .live_i (shreg_w),
    .sw_en_o(sw_en_o)
  );
endmodule

// File: rtl/swctl_shift_latch_chk.sv
module swctl_shift_latch_chk #(
  parameter int unsigned NUM_SW = 8
) (
  input logic              sclk_i,
  input logic              rst_ni,
  input logic              sdi_i,
  input logic              load_ni,
  input logic              clr_i,
  input logic [NUM_SW-1:0] sw_en_o,
  input logic              sdo_o,
  input logic [NUM_SW-1:0] shreg_w,
  input logic              cap_tog_w
);
  // R1: one step of the shift per serial clock
  p_shift_step_r1: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    1'b1 |=> shreg_w == {$past(shreg_w[NUM_SW-2:0]), $past(sdi_i)});

  // R2: the serial output shows what stage N-2 held one clock earlier
  p_cascade_tap_r2: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    1'b1 |=> sdo_o == $past(shreg_w[NUM_SW-2]));

  // R3: the open latch passes the register
  p_transparent_r3: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    (!load_ni && !clr_i) |-> sw_en_o == shreg_w);

  // R4: the closed latch, with no new capture, keeps the outputs steady
  p_hold_stable_r4: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    (load_ni && $past(load_ni) && !clr_i && !$past(clr_i) && $stable(cap_tog_w))
      |-> $stable(sw_en_o));

  // R5: clear forces every switch off
  p_clear_off_r5: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    clr_i |-> sw_en_o == '0);
endmodule

bind swctl_shift_latch swctl_shift_latch_chk #(.NUM_SW(NUM_SW)) u_chk (
  .sclk_i   (sclk_i),
  .rst_ni   (rst_ni),
  .sdi_i    (sdi_i),
  .load_ni  (load_ni),
  .clr_i    (clr_i),
  .sw_en_o  (sw_en_o),
  .sdo_o    (sdo_o),
  .shreg_w  (shreg_w),
  .cap_tog_w(cap_tog_w)
);

// File: tb/swctl_shift_latch_bench.sv
module swctl_shift_latch_bench;
  localparam int CLK_PERIOD = 50;  // 20 MHz serial clock
  localparam int NPAT = 8;
  localparam logic [7:0] PATS [NPAT] = '{8'h01, 8'h80, 8'h5A, 8'hA5,
                                          8'hFF, 8'h00, 8'h3C, 8'hC3};

  logic       sclk, rst_n, sdi, load_n, clr;
  logic [7:0] sw_head, sw_tail;
  logic       sdo_head, sdo_tail;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] model;   // bench's own view of the chained register
  logic [7:0]  exp_hold;

  swctl_shift_latch u_swctl_shift_latch (
    .sclk_i(sclk), .rst_ni(rst_n), .sdi_i(sdi), .load_ni(load_n),
    .clr_i(clr), .sw_en_o(sw_head), .sdo_o(sdo_head));

  swctl_shift_latch u_swctl_shift_latch_tail (
    .sclk_i(sclk), .rst_ni(rst_n), .sdi_i(sdo_head), .load_ni(load_n),
    .clr_i(clr), .sw_en_o(sw_tail), .sdo_o(sdo_tail));

  task automatic check(input string req, input logic [7:0] act,
                       input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic shift_bit(input logic b);
    sdi = b;
    #(CLK_PERIOD/2) sclk = 1'b1;
    model = {model[14:0], b};
    #(CLK_PERIOD/2) sclk = 1'b0;
    #1;
  endtask

  task automatic shift_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) shift_bit(v[i]);
  endtask

  task automatic set_load(input logic v);
    #(CLK_PERIOD/2) load_n = v;
    #(CLK_PERIOD/2);
  endtask

  task automatic set_clr(input logic v);
    #(CLK_PERIOD/2) clr = v;
    #(CLK_PERIOD/2);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    sclk = 0; rst_n = 0; sdi = 0; load_n = 1; clr = 0; model = '0;
    exp_hold = '0;
    #(CLK_PERIOD * 2);
    // R8: reset state
    check("R8 head outputs", sw_head, 8'h00);
    check("R8 head sdo", {7'd0, sdo_head}, 8'h00);
    check("R8 tail outputs", sw_tail, 8'h00);
    rst_n = 1;
    #(CLK_PERIOD);

    // Table: shift with latch closed, open, close again
    for (int k = 0; k < NPAT; k++) begin
      shift_byte(PATS[k]);
      check("R4 frozen during shift", sw_head, exp_hold);
      check("R2 sdo is stage 7", {7'd0, sdo_head}, {7'd0, model[7]});
      set_load(1'b0);
      check("R3 R7 open latch shows bits", sw_head, model[7:0]);
      set_load(1'b1);
      exp_hold = model[7:0];
      check("R4 held after rise", sw_head, exp_hold);
    end

    // R1: direction and depth of the shift, latch open
    set_load(1'b0);
    shift_byte(8'h00);
    shift_bit(1'b1);
    check("R1 new bit at stage 0", sw_head, 8'h01);
    for (int i = 0; i < 7; i++) shift_bit(1'b0);
    check("R1 first bit at stage 7 after eight", sw_head, 8'h80);
    check("R2 sdo high with stage 7 set", {7'd0, sdo_head}, 8'h01);

    // R4: capture exactly at the rising edge
    shift_byte(8'h96);
    set_load(1'b1);
    shift_byte(8'h0F);
    check("R4 captured value kept", sw_head, 8'h96);
    check("R2 sdo follows register not latch", {7'd0, sdo_head}, 8'h00);
    set_load(1'b0);
    check("R3 reopen shows register", sw_head, 8'h0F);

    // R5/R6: clear with latch open
    shift_byte(8'hE1);
    set_clr(1'b1);
    check("R5 clear forces off", sw_head, 8'h00);
    check("R6 register kept during clear", {7'd0, sdo_head}, 8'h01);
    shift_byte(8'h42);
    check("R5 clear overrides shifting", sw_head, 8'h00);
    set_clr(1'b0);
    check("R6 release shows register", sw_head, 8'h42);

    // R10: clear with latch closed
    set_load(1'b1);
    check("R4 closed holds 42", sw_head, 8'h42);
    set_clr(1'b1);
    check("R5 clear with latch closed", sw_head, 8'h00);
    set_clr(1'b0);
    check("R10 stays off after release", sw_head, 8'h00);
    shift_byte(8'h77);
    check("R10 stays off while shifting", sw_head, 8'h00);
    set_load(1'b0);
    check("R10 load low shows register", sw_head, 8'h77);
    set_load(1'b1);

    // R9: two-block chain with a 16-bit stream
    for (int i = 15; i >= 0; i--) shift_bit(16'hC35A >> i);
    check("R9 outputs frozen during chain load", sw_head, 8'h77);
    set_load(1'b0);
    check("R9 head gets low byte", sw_head, model[7:0]);
    check("R9 tail gets high byte", sw_tail, model[15:8]);
    check("R9 tail value", sw_tail, 8'hC3);
    check("R9 tail sdo", {7'd0, sdo_tail}, 8'h01);

    // R8: reset in a loaded state
    rst_n = 0;
    #(CLK_PERIOD);
    check("R8 reset clears outputs", sw_head, 8'h00);
    check("R8 reset clears sdo", {7'd0, sdo_head}, 8'h00);
    check("R8 reset clears tail", sw_tail, 8'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule